// File: doc/BRIEF.md
# Output Voltage Power-Good Qualifier

This block decides when a regulated output may be declared good. It receives digitized output-voltage samples, each marked by a one-cycle valid strobe. Each sample is compared against a tolerance window placed around a programmable target code. The upper and lower edges of the window are given as whole-percent margins of the target. The power-good flag rises only after the output has stayed inside the window, with no fault reported, for a qualification delay counted in milliseconds.

The qualification delay normally follows the soft-start ramp-time setting. When the override enable is set, a separate delay setting is used instead. The flag falls on the next clock edge after any of these events:
- a captured sample lies outside the window, including an overvoltage sample above the upper edge;
- the fault input goes high.

After the flag falls, the delay timer starts again from zero. A millisecond prescaler, sized by a parameter, turns system clock cycles into delay ticks. All configuration inputs are expected to be held static by the surrounding register logic.

Top module: `pwrgood_monitor`

## Requirements
- R1: While `rst` is high, `pg_out` is 0. After reset it stays 0 until an in-window sample has been captured and the delay has run out.
- R2: The upper bound is target + floor(target*hi_pct/100). The lower bound is target - floor(target*lo_pct/100), clamped to 0 when the subtracted share is larger than the target. A sample is in-window when lower <= sample <= upper, with both ends included.
- R3: With margins hi_pct=15 and lo_pct=10 and a target of 1000, samples from 900 to 1150 are in-window. Samples of 899 and 1151 are not.
- R4: With `dly_ovr_en`=0, the delay D is taken from `ss_ms`. `pg_out` rises on the (D*TICKS_PER_MS+1)-th rising edge after the edge that captures the first in-window sample, provided `fault_in` stays 0.
- R5: With `dly_ovr_en`=1, the delay is taken from `dly_ms`, and `ss_ms` has no effect on the timing.
- R6: With a delay of 0, `pg_out` rises on the first rising edge after the capturing edge.
- R7: Any loss of the conditions (an out-of-window sample or a fault) clears the flag and the timer. When the conditions return, the full delay is counted again from zero.
- R8: `fault_in`=1 forces `pg_out` to 0 at the next rising edge and keeps it there for as long as the fault stays high.
- R9: A captured sample above the upper bound (overvoltage) drives `pg_out` to 0 on the next rising edge.
- R10: `samp_code` is ignored while `samp_valid` is 0. The window verdict from the last captured sample is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_valid | input | 1 | One-cycle strobe that marks a new voltage sample |
| samp_code | input | VW | Digitized output-voltage sample |
| tgt_code | input | VW | Target output-voltage code |
| hi_pct | input | PW | Upper margin in whole percent of the target |
| lo_pct | input | PW | Lower margin in whole percent of the target |
| ss_ms | input | DW | Soft-start ramp time in ms, the default delay |
| dly_ms | input | DW | Separately programmed delay in ms |
| dly_ovr_en | input | 1 | 1 selects `dly_ms`, 0 selects `ss_ms` |
| fault_in | input | 1 | Active-high fault indication |
| pg_out | output | 1 | Registered power-good flag |

## Verification
The hardest case to reach is a dropout in the middle of a running delay. Checking it needs an in-window sample, then an out-of-window sample partway through the delay count, then an in-window sample again. After that, the bench must show that the flag is still low one cycle before a full fresh delay has passed. The bench uses a small prescaler setting so that millisecond delays take only a few cycles. It places each sample strobe on an exact cycle and counts edges from the edge that captures the sample. A fault pulse that arrives while in-window samples are still being captured is used to show that the fault alone holds the flag down.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int unsigned PCT_DIV = 100;

  typedef enum logic [1:0] {
    WIN_BELOW  = 2'd0,
    WIN_INSIDE = 2'd1,
    WIN_ABOVE  = 2'd2
  } win_pos_e;
endpackage

// File: rtl/pg_window_limits.sv
module pg_window_limits #(
  parameter int VW = 12,
  parameter int PW = 8,
  localparam int LW = VW + PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [VW-1:0] tgt_code,
  input  logic [PW-1:0] hi_pct,
  input  logic [PW-1:0] lo_pct,
  output logic [LW-1:0] hi_lim,
  output logic [LW-1:0] lo_lim
);
  import pg_pkg::*;

  logic [LW-1:0] tgt_w;
  logic [LW-1:0] hi_share;
  logic [LW-1:0] lo_share;
  logic [LW-1:0] hi_next;
  logic [LW-1:0] lo_next;

  always_comb begin
    tgt_w    = LW'(tgt_code);
    hi_share = (tgt_w * LW'(hi_pct)) / LW'(PCT_DIV);
    lo_share = (tgt_w * LW'(lo_pct)) / LW'(PCT_DIV);
    hi_next  = tgt_w + hi_share;
    lo_next  = (lo_share > tgt_w) ? '0 : (tgt_w - lo_share);
  end

  // Reset places the window so that no sample can be inside it
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_lim <= '0;
      lo_lim <= '1;
    end else begin
      hi_lim <= hi_next;
      lo_lim <= lo_next;
    end
  end
endmodule

// File: rtl/pg_window_check.sv
module pg_window_check #(
  parameter int VW = 12,
  parameter int LW = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             samp_valid,
  input  logic [VW-1:0]    samp_code,
  input  logic [LW-1:0]    hi_lim,
  input  logic [LW-1:0]    lo_lim,
  output pg_pkg::win_pos_e win_pos
);
  import pg_pkg::*;

  logic [LW-1:0] samp_w;
  assign samp_w = LW'(samp_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_pos <= WIN_BELOW;
    end else if (samp_valid) begin
      if (samp_w > hi_lim)      win_pos <= WIN_ABOVE;
      else if (samp_w < lo_lim) win_pos <= WIN_BELOW;
      else                      win_pos <= WIN_INSIDE;
    end
  end
endmodule

// File: rtl/pg_qual_timer.sv
module pg_qual_timer #(
  parameter int DW           = 16,
  parameter int TICKS_PER_MS = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          qual_ok,
  input  logic [DW-1:0] delay_ms,
  output logic          pg
);
  localparam int PSW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;

  logic          ms_step;
  logic [DW-1:0] ms_cnt;

  generate
    if (TICKS_PER_MS > 1) begin : g_presc
      logic [PSW-1:0] pre_cnt;
      assign ms_step = (pre_cnt == PSW'(TICKS_PER_MS - 1));
      always_ff @(posedge clk) begin
        if (rst || !qual_ok) pre_cnt <= '0;
        else if (ms_step)    pre_cnt <= '0;
        else                 pre_cnt <= pre_cnt + 1'b1;
      end
    end else begin : g_direct
      assign ms_step = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !qual_ok) begin
      ms_cnt <= '0;
      pg     <= 1'b0;
    end else begin
      if (ms_step && (ms_cnt != '1)) ms_cnt <= ms_cnt + 1'b1;
      pg <= pg | (ms_cnt >= delay_ms);
    end
  end
endmodule

// File: rtl/pwrgood_monitor.sv
module pwrgood_monitor #(
  parameter int VW           = 12,
  parameter int PW           = 8,
  parameter int DW           = 16,
  parameter int TICKS_PER_MS = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          samp_valid,
  input  logic [VW-1:0] samp_code,
  input  logic [VW-1:0] tgt_code,
  input  logic [PW-1:0] hi_pct,
  input  logic [PW-1:0] lo_pct,
  input  logic [DW-1:0] ss_ms,
  input  logic [DW-1:0] dly_ms,
  input  logic          dly_ovr_en,
  input  logic          fault_in,
  output logic          pg_out
);
  import pg_pkg::*;

  localparam int LW = VW + PW;

  logic [LW-1:0] hi_lim;
  logic [LW-1:0] lo_lim;
  win_pos_e      win_pos;
  logic          win_ok;
  logic          win_ovr;
  logic          qual_ok;
  logic [DW-1:0] eff_delay;

  pg_window_limits #(.VW(VW), .PW(PW)) u_limits (
    .clk(clk), .rst(rst), .tgt_code(tgt_code),
    .hi_pct(hi_pct), .lo_pct(lo_pct),
    .hi_lim(hi_lim), .lo_lim(lo_lim)
  );

  pg_window_check #(.VW(VW), .LW(LW)) u_check (
    .clk(clk), .rst(rst), .samp_valid(samp_valid), .samp_code(samp_code),
    .hi_lim(hi_lim), .lo_lim(lo_lim), .win_pos(win_pos)
  );

  assign win_ok    = (win_pos == WIN_INSIDE);
  assign win_ovr   = (win_pos == WIN_ABOVE);
  assign qual_ok   = win_ok && !fault_in;
  assign eff_delay = dly_ovr_en ? dly_ms : ss_ms;

  pg_qual_timer #(.DW(DW), .TICKS_PER_MS(TICKS_PER_MS)) u_timer (
    .clk(clk), .rst(rst), .qual_ok(qual_ok),
    .delay_ms(eff_delay), .pg(pg_out)
  );
endmodule

// File: rtl/pwrgood_monitor_chk.sv
module pwrgood_monitor_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          samp_valid,
  input logic          fault_in,
  input logic          dly_ovr_en,
  input logic [DW-1:0] dly_ms,
  input logic          win_ok,
  input logic          win_ovr,
  input logic          pg_out
);
  AST_RESET_LOW: assert property (@(posedge clk) rst |=> !pg_out); // R1
  AST_WIN_LOSS_DROPS: assert property (@(posedge clk) disable iff (rst) !win_ok |=> !pg_out); // R7
  AST_FAULT_DROPS: assert property (@(posedge clk) disable iff (rst) fault_in |=> !pg_out); // R8
  AST_OVERVOLT_DROPS: assert property (@(posedge clk) disable iff (rst) win_ovr |=> !pg_out); // R9
  AST_ZERO_DELAY_RISE: assert property (@(posedge clk) disable iff (rst)
    (dly_ovr_en && (dly_ms == '0) && win_ok && !fault_in) |=> pg_out); // R6
  AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (rst) !samp_valid |=> $stable(win_ok)); // R10
endmodule

bind pwrgood_monitor pwrgood_monitor_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .samp_valid(samp_valid), .fault_in(fault_in),
  .dly_ovr_en(dly_ovr_en), .dly_ms(dly_ms), .win_ok(win_ok),
  .win_ovr(win_ovr), .pg_out(pg_out)
);

// File: tb/tb_pwrgood_monitor.sv
`timescale 1ns/1ps
module tb_pwrgood_monitor;
  localparam int VW = 12;
  localparam int PW = 8;
  localparam int DW = 16;
  localparam int TPM = 4;
  localparam int NV = 14;

  // {target, hi_pct, lo_pct, sample, expected pg with zero delay}
  localparam logic [40:0] VEC [0:NV-1] = '{
    {12'd1000, 8'd15,  8'd10,  12'd1150, 1'b1},
    {12'd1000, 8'd15,  8'd10,  12'd1151, 1'b0},
    {12'd1000, 8'd15,  8'd10,  12'd900,  1'b1},
    {12'd1000, 8'd15,  8'd10,  12'd899,  1'b0},
    {12'd1000, 8'd15,  8'd10,  12'd1000, 1'b1},
    {12'd2000, 8'd5,   8'd5,   12'd2101, 1'b0},
    {12'd2000, 8'd5,   8'd5,   12'd2100, 1'b1},
    {12'd333,  8'd10,  8'd20,  12'd367,  1'b0},
    {12'd333,  8'd10,  8'd20,  12'd366,  1'b1},
    {12'd333,  8'd10,  8'd20,  12'd266,  1'b0},
    {12'd333,  8'd10,  8'd20,  12'd267,  1'b1},
    {12'd100,  8'd0,   8'd150, 12'd101,  1'b0},
    {12'd100,  8'd0,   8'd150, 12'd0,    1'b1},
    {12'd4095, 8'd15,  8'd10,  12'd4095, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic samp_valid = 1'b0;
  logic [VW-1:0] samp_code = '0;
  logic [VW-1:0] tgt_code = '0;
  logic [PW-1:0] hi_pct = '0;
  logic [PW-1:0] lo_pct = '0;
  logic [DW-1:0] ss_ms = '0;
  logic [DW-1:0] dly_ms = '0;
  logic dly_ovr_en = 1'b1;
  logic fault_in = 1'b0;
  logic pg_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwrgood_monitor #(.VW(VW), .PW(PW), .DW(DW), .TICKS_PER_MS(TPM)) dut (
    .clk(clk), .rst(rst), .samp_valid(samp_valid), .samp_code(samp_code),
    .tgt_code(tgt_code), .hi_pct(hi_pct), .lo_pct(lo_pct), .ss_ms(ss_ms),
    .dly_ms(dly_ms), .dly_ovr_en(dly_ovr_en), .fault_in(fault_in),
    .pg_out(pg_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pg_out got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [VW-1:0] t, input logic [PW-1:0] h, input logic [PW-1:0] l);
    tgt_code = t; hi_pct = h; lo_pct = l;
    repeat (2) @(negedge clk);
  endtask

  // Leaves the bench just after the capturing edge
  task automatic capture(input logic [VW-1:0] code);
    samp_code = code;
    samp_valid = 1'b1;
    @(negedge clk);
    samp_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", pg_out, 1'b0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 no sample after reset", pg_out, 1'b0);

    // Table walk, zero delay
    for (int i = 0; i < NV; i++) begin
      set_cfg(VEC[i][40:29], VEC[i][28:21], VEC[i][20:13]);
      capture(VEC[i][12:1]);
      @(negedge clk);
      check((i < 5) ? "R3 default margins" : "R2 bound formula", pg_out, VEC[i][0]);
    end

    // R6 zero delay then R9 overvoltage
    set_cfg(12'd1000, 8'd15, 8'd10);
    capture(12'd500);
    @(negedge clk);
    capture(12'd1000);
    @(negedge clk);
    check("R6 zero delay rise", pg_out, 1'b1);
    capture(12'd1200);
    @(negedge clk);
    check("R9 overvoltage drop", pg_out, 1'b0);

    // R10 strobe-less sample ignored
    capture(12'd1000);
    @(negedge clk);
    samp_code = 12'd1300;
    repeat (5) @(negedge clk);
    check("R10 code ignored without strobe", pg_out, 1'b1);

    // R8 fault
    fault_in = 1'b1;
    @(negedge clk);
    check("R8 fault drop", pg_out, 1'b0);
    capture(12'd1000);
    repeat (2) @(negedge clk);
    check("R8 held low during fault", pg_out, 1'b0);
    fault_in = 1'b0;
    @(negedge clk);
    check("R8 release", pg_out, 1'b1);

    // R4 delay from soft-start setting
    capture(12'd500);
    @(negedge clk);
    dly_ovr_en = 1'b0; ss_ms = 16'd3; dly_ms = 16'd0;
    capture(12'd1000);
    repeat (12) @(negedge clk);
    check("R4 before soft-start delay", pg_out, 1'b0);
    @(negedge clk);
    check("R4 at soft-start delay", pg_out, 1'b1);

    // R5 override delay
    capture(12'd500);
    @(negedge clk);
    dly_ovr_en = 1'b1; dly_ms = 16'd1; ss_ms = 16'd3;
    capture(12'd1000);
    repeat (4) @(negedge clk);
    check("R5 before override delay", pg_out, 1'b0);
    @(negedge clk);
    check("R5 at override delay", pg_out, 1'b1);

    // R7 dropout mid-delay restarts the full delay
    capture(12'd500);
    @(negedge clk);
    dly_ms = 16'd2;
    capture(12'd1000);
    repeat (5) @(negedge clk);
    capture(12'd1300);
    @(negedge clk);
    check("R7 dropout clears", pg_out, 1'b0);
    capture(12'd1000);
    repeat (8) @(negedge clk);
    check("R7 full delay restarted", pg_out, 1'b0);
    @(negedge clk);
    check("R7 rise after full delay", pg_out, 1'b1);

    // R1 reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears", pg_out, 1'b0);
    rst = 1'b0;
    dly_ms = 16'd0;
    repeat (3) @(negedge clk);
    check("R1 stays low after reset", pg_out, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule